// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the software-facing register file of an SMBus host controller. A CPU-side agent reaches it over a simple byte-wide register bus with a 6-bit offset. Through that bus it loads a target address, a command byte, two data bytes and a 32-entry block buffer, then starts a transaction by writing the control register with the start bit set. The front end decodes the protocol field. For a supported protocol, it latches one request and holds it toward a downstream bus master until that master acknowledges it. For an unsupported protocol, it flags an error and issues nothing.

The downstream side uses a level request / single-cycle acknowledge handshake. The request carries the protocol code, the read flag, the 7-bit target address, the command, a byte count and sixteen bits of write data. Block bytes move over a separate byte channel, always in buffer order starting from entry 0. For a block read, the master pushes bytes into the buffer. For a block write, the master pulls bytes out of it. On acknowledge, returned read data lands in the data registers and status reports completion.

A single block index is shared by reads and writes of the block data register. It moves through the buffer automatically and can be rewound by software.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register, the block buffer and the block index are 0, and no request is raised.
- R2: Offsets are: status 0x00, control 0x02, command 0x03, address 0x04, data-low 0x05, data-high 0x06, block data 0x07. Reads of any other offset return 0x00.
- R3: A control read returns the stored control value with bits 7:5 forced to 0, and sets the block index to 0.
- R4: Each block data access returns or writes buffer[index] and then advances the index. After entry 31, the index wraps to 0.
- R5: Writing any value to status clears done (bit 1) and error (bit 2) and sets the block index to 0.
- R6: A control write with bit 6 set, while idle, with protocol code bits 4:2 in {0,1,2,3,5}, raises txn_req from the next cycle. txn_req holds until acknowledged. The request carries these fields, frozen at the start: protocol code, read flag = address bit 0, target = address bits 7:1, command, count = data-low, and write data = {data-high, data-low}.
- R7: A start with protocol code 4, 6 or 7 sets status bit 2 and raises no request.
- R8: Status bit 0 reads 1 exactly while a request is outstanding. A control write during that time changes nothing and starts nothing.
- R9: One cycle with txn_ack high while a request is outstanding drops txn_req on the next cycle, clears busy and sets status bit 1.
- R10: On acknowledge of a read, txn_rdata[7:0] is loaded into data-low for codes 1, 2, 3 and 5, and txn_rdata[15:8] is loaded into data-high for code 3. Write transactions and code 0 leave both data registers unchanged.
- R11: During an outstanding block transaction, a stream pointer starts at entry 0. For a block read, each cycle with blk_in_valid writes blk_in_byte to buffer[pointer] and advances the pointer. For a block write, blk_out_byte shows buffer[pointer], and each blk_out_pull advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables read side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| txn_req | output | 1 | Transaction request, held until acknowledge |
| txn_proto | output | 3 | Protocol code of the request |
| txn_read | output | 1 | 1 for read, 0 for write |
| txn_addr | output | 7 | Target address |
| txn_cmd | output | 8 | Command byte |
| txn_count | output | 8 | Block byte count |
| txn_wdata | output | 16 | Write data {high, low} |
| txn_ack | input | 1 | Transaction completion |
| txn_rdata | input | 16 | Returned read data {high, low} or block count in low byte |
| blk_in_valid | input | 1 | Block read byte strobe |
| blk_in_byte | input | 8 | Block read byte |
| blk_out_pull | input | 1 | Block write byte consumed |
| blk_out_byte | output | 8 | Block write byte at stream pointer |

## Verification
The bench aims at the block index. It writes 33 bytes so the last one wraps onto entry 0, and it rewinds the index both by a status write and by a control read. A design that wrapped late, or that skipped one of the rewinds, returns the wrong buffer byte. It also writes control while a request is outstanding: a design that accepted that write would show a changed control value or a second request. Unsupported protocol codes must leave txn_req low with the error bit set. Read acknowledges must fill exactly the data registers their protocol names, so a word read that dropped the high byte, or a write that disturbed data-low, shows up on readback.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 6;

    localparam logic [OFS_W-1:0] OFS_STS = 6'h00;
    localparam logic [OFS_W-1:0] OFS_CTL = 6'h02;
    localparam logic [OFS_W-1:0] OFS_CMD = 6'h03;
    localparam logic [OFS_W-1:0] OFS_ADR = 6'h04;
    localparam logic [OFS_W-1:0] OFS_DLO = 6'h05;
    localparam logic [OFS_W-1:0] OFS_DHI = 6'h06;
    localparam logic [OFS_W-1:0] OFS_BLK = 6'h07;

    localparam int CTL_START = 6;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd5;

    typedef struct packed {
        logic [2:0]        proto;
        logic              rd;
        logic [6:0]        tgt;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] count;
        logic [15:0]       wdata;
    } smb_req_t;
endpackage

// File: rtl/smb_proto_decode.sv
module smb_proto_decode
    import smb_host_pkg::*;
(
    input  logic [2:0] code,
    output logic       supported,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       is_block
);
    always_comb begin
        supported = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        is_block  = 1'b0;
        case (code)
            PR_QUICK: supported = 1'b1;
            PR_BYTE, PR_BDATA: begin
                supported = 1'b1;
                cap_lo    = 1'b1;
            end
            PR_WORD: begin
                supported = 1'b1;
                cap_lo    = 1'b1;
                cap_hi    = 1'b1;
            end
            PR_BLOCK: begin
                supported = 1'b1;
                cap_lo    = 1'b1;
                is_block  = 1'b1;
            end
            default: supported = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_en,
    input  logic [$clog2(DEPTH)-1:0] wa_idx,
    input  logic [W-1:0]             wa_data,
    input  logic                     wb_en,
    input  logic [$clog2(DEPTH)-1:0] wb_idx,
    input  logic [W-1:0]             wb_data,
    input  logic [$clog2(DEPTH)-1:0] ra_idx,
    output logic [W-1:0]             ra_data,
    input  logic [$clog2(DEPTH)-1:0] rb_idx,
    output logic [W-1:0]             rb_data
);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wb_en && wb_idx == IW'(e)) begin
                mem[e] <= wb_data;
            end else if (wa_en && wa_idx == IW'(e)) begin
                mem[e] <= wa_data;
            end
        end
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              txn_req,
    output logic [2:0]        txn_proto,
    output logic              txn_read,
    output logic [6:0]        txn_addr,
    output logic [BYTE_W-1:0] txn_cmd,
    output logic [BYTE_W-1:0] txn_count,
    output logic [15:0]       txn_wdata,
    input  logic              txn_ack,
    input  logic [15:0]       txn_rdata,
    input  logic              blk_in_valid,
    input  logic [BYTE_W-1:0] blk_in_byte,
    input  logic              blk_out_pull,
    output logic [BYTE_W-1:0] blk_out_byte
);
    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_DEPTH - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] adr;
        logic [BYTE_W-1:0] dlo;
        logic [BYTE_W-1:0] dhi;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  sptr;
        logic              busy;
        logic              done;
        logic              err;
        smb_req_t          req;
    } st_t;

    st_t st_d, st_q;

    logic              new_ok, new_lo, new_hi, new_blk;
    logic              cur_ok, cur_lo, cur_hi, cur_blk;
    logic              wa_en, wb_en;
    logic [BYTE_W-1:0] buf_ra, buf_rb;

    smb_proto_decode u_dec_new (
        .code      (reg_wdata[4:2]),
        .supported (new_ok),
        .cap_lo    (new_lo),
        .cap_hi    (new_hi),
        .is_block  (new_blk)
    );

    smb_proto_decode u_dec_cur (
        .code      (st_q.req.proto),
        .supported (cur_ok),
        .cap_lo    (cur_lo),
        .cap_hi    (cur_hi),
        .is_block  (cur_blk)
    );

    smb_blk_buf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_idx  (st_q.idx),
        .wa_data (reg_wdata),
        .wb_en   (wb_en),
        .wb_idx  (st_q.sptr),
        .wb_data (blk_in_byte),
        .ra_idx  (st_q.idx),
        .ra_data (buf_ra),
        .rb_idx  (st_q.sptr),
        .rb_data (buf_rb)
    );

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
        return (v == IDX_LAST) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        wa_en = 1'b0;
        wb_en = 1'b0;

        if (reg_wr) begin
            case (reg_addr)
                OFS_STS: begin
                    st_d.done = 1'b0;
                    st_d.err  = 1'b0;
                    st_d.idx  = '0;
                end
                OFS_CTL: begin
                    if (!st_q.busy) begin
                        st_d.ctrl = reg_wdata;
                        if (reg_wdata[CTL_START]) begin
                            if (new_ok) begin
                                st_d.busy      = 1'b1;
                                st_d.sptr      = '0;
                                st_d.req.proto = reg_wdata[4:2];
                                st_d.req.rd    = st_q.adr[0];
                                st_d.req.tgt   = st_q.adr[7:1];
                                st_d.req.cmd   = st_q.cmd;
                                st_d.req.count = st_q.dlo;
                                st_d.req.wdata = {st_q.dhi, st_q.dlo};
                            end else begin
                                st_d.err = 1'b1;
                            end
                        end
                    end
                end
                OFS_CMD: st_d.cmd = reg_wdata;
                OFS_ADR: st_d.adr = reg_wdata;
                OFS_DLO: st_d.dlo = reg_wdata;
                OFS_DHI: st_d.dhi = reg_wdata;
                OFS_BLK: begin
                    wa_en    = 1'b1;
                    st_d.idx = bump(st_q.idx);
                end
                default: ;
            endcase
        end else if (reg_rd) begin
            case (reg_addr)
                OFS_CTL: st_d.idx = '0;
                OFS_BLK: st_d.idx = bump(st_q.idx);
                default: ;
            endcase
        end

        if (st_q.busy && cur_blk) begin
            if (st_q.req.rd && blk_in_valid) begin
                wb_en     = 1'b1;
                st_d.sptr = bump(st_q.sptr);
            end else if (!st_q.req.rd && blk_out_pull) begin
                st_d.sptr = bump(st_q.sptr);
            end
        end

        if (st_q.busy && txn_ack) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            if (st_q.req.rd && cur_ok) begin
                if (cur_lo) st_d.dlo = txn_rdata[7:0];
                if (cur_hi) st_d.dhi = txn_rdata[15:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_STS: reg_rdata = {5'b0, st_q.err, st_q.done, st_q.busy};
            OFS_CTL: reg_rdata = {3'b0, st_q.ctrl[4:0]};
            OFS_CMD: reg_rdata = st_q.cmd;
            OFS_ADR: reg_rdata = st_q.adr;
            OFS_DLO: reg_rdata = st_q.dlo;
            OFS_DHI: reg_rdata = st_q.dhi;
            OFS_BLK: reg_rdata = buf_ra;
            default: reg_rdata = '0;
        endcase
    end

    assign txn_req      = st_q.busy;
    assign txn_proto    = st_q.req.proto;
    assign txn_read     = st_q.req.rd;
    assign txn_addr     = st_q.req.tgt;
    assign txn_cmd      = st_q.req.cmd;
    assign txn_count    = st_q.req.count;
    assign txn_wdata    = st_q.req.wdata;
    assign blk_out_byte = buf_rb;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
    import smb_host_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFS_W-1:0]  reg_addr,
    input logic              reg_wr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              txn_req,
    input logic              txn_ack
);
    logic mapped;
    assign mapped = (reg_addr == OFS_STS) || (reg_addr >= OFS_CTL && reg_addr <= OFS_BLK);

    logic bad_start;
    assign bad_start = reg_wr && reg_addr == OFS_CTL && reg_wdata[CTL_START] &&
                       (reg_wdata[4:2] == 3'd4 || reg_wdata[4:2] == 3'd6 || reg_wdata[4:2] == 3'd7);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !mapped |-> reg_rdata == '0); // R2
    AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n) reg_addr == OFS_CTL |-> reg_rdata[7:5] == 3'b0); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) txn_req && !txn_ack |=> txn_req); // R6
    AST_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(txn_req) |-> $past(reg_wr && reg_addr == OFS_CTL && reg_wdata[CTL_START])); // R6
    AST_BAD_PROTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !txn_req && bad_start |=> !txn_req); // R7
    AST_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n) reg_addr == OFS_STS |-> reg_rdata[0] == txn_req); // R8
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) txn_req && txn_ack |=> !txn_req); // R9
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .txn_req   (txn_req),
    .txn_ack   (txn_ack)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        txn_req, txn_read;
    logic [2:0]  txn_proto;
    logic [6:0]  txn_addr;
    logic [7:0]  txn_cmd, txn_count, blk_out_byte;
    logic [15:0] txn_wdata;
    logic        txn_ack = 1'b0;
    logic [15:0] txn_rdata = '0;
    logic        blk_in_valid = 1'b0, blk_out_pull = 1'b0;
    logic [7:0]  blk_in_byte = '0;

    always #4 clk = ~clk;

    smb_host_regs u_dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [7:0] m_ctrl, m_cmd, m_adr, m_dlo, m_dhi;
    logic [7:0] m_buf [32];
    int         m_idx;
    bit         m_busy, m_done, m_err;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit proto_ok(input logic [2:0] p);
        return p == 0 || p == 1 || p == 2 || p == 3 || p == 5;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00: return {5'b0, m_err, m_done, m_busy};
            6'h02: return {3'b0, m_ctrl[4:0]};
            6'h03: return m_cmd;
            6'h04: return m_adr;
            6'h05: return m_dlo;
            6'h06: return m_dhi;
            6'h07: return m_buf[m_idx];
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        case (a)
            6'h00: begin m_done = 0; m_err = 0; m_idx = 0; end
            6'h02: if (!m_busy) begin
                m_ctrl = d;
                if (d[6]) begin
                    if (proto_ok(d[4:2])) m_busy = 1; else m_err = 1;
                end
            end
            6'h03: m_cmd = d;
            6'h04: m_adr = d;
            6'h05: m_dlo = d;
            6'h06: m_dhi = d;
            6'h07: begin m_buf[m_idx] = d; m_idx = (m_idx + 1) % 32; end
            default: ;
        endcase
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 check(tag, reg_rdata, exp_rd(a));
        @(posedge clk);
        if (a == 6'h02) m_idx = 0;
        if (a == 6'h07) m_idx = (m_idx + 1) % 32;
        #1 reg_rd = 1'b0;
    endtask

    task automatic run_txn(input logic [2:0] pr, input bit rdf, input logic [6:0] a7,
                           input logic [7:0] cmd, input logic [7:0] dlo, input logic [7:0] dhi,
                           input logic [15:0] resp, input int nblk);
        wr(6'h04, {a7, rdf});
        wr(6'h03, cmd);
        wr(6'h05, dlo);
        wr(6'h06, dhi);
        wr(6'h02, 8'h40 | {3'b0, pr, 2'b0});
        @(negedge clk);
        check("R6 req raised", txn_req, 1);
        check("R6 proto", txn_proto, pr);
        check("R6 read flag", txn_read, rdf);
        check("R6 target", txn_addr, a7);
        check("R6 cmd", txn_cmd, cmd);
        check("R6 count", txn_count, dlo);
        check("R6 wdata", txn_wdata, {dhi, dlo});
        rd(6'h00, "R8 busy set");
        wr(6'h02, 8'h5f);
        rd(6'h02, "R8 ctl write ignored while busy");
        wr(6'h04, 8'hff);
        @(negedge clk);
        check("R6 fields frozen", {txn_addr, txn_read}, {a7, rdf});
        check("R8 single request held", txn_req, 1);
        if (pr == 3'd5 && rdf) begin
            for (int i = 0; i < nblk; i++) begin
                @(negedge clk);
                blk_in_valid = 1'b1; blk_in_byte = 8'($urandom);
                m_buf[i] = blk_in_byte;
                @(posedge clk);
                #1 blk_in_valid = 1'b0;
            end
        end
        if (pr == 3'd5 && !rdf) begin
            for (int i = 0; i < nblk; i++) begin
                @(negedge clk);
                check("R11 block out byte", blk_out_byte, m_buf[i]);
                blk_out_pull = 1'b1;
                @(posedge clk);
                #1 blk_out_pull = 1'b0;
            end
        end
        @(negedge clk);
        txn_ack = 1'b1; txn_rdata = resp;
        @(posedge clk);
        m_busy = 0; m_done = 1;
        if (rdf) begin
            if (pr == 1 || pr == 2 || pr == 3 || pr == 5) m_dlo = resp[7:0];
            if (pr == 3) m_dhi = resp[15:8];
        end
        #1 txn_ack = 1'b0;
        @(negedge clk);
        check("R9 req dropped", txn_req, 0);
        rd(6'h00, "R9 done set");
        rd(6'h05, "R10 data-low");
        rd(6'h06, "R10 data-high");
        wr(6'h00, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_ctrl = 0; m_cmd = 0; m_adr = 0; m_dlo = 0; m_dhi = 0;
        m_idx = 0; m_busy = 0; m_done = 0; m_err = 0;
        for (int i = 0; i < 32; i++) m_buf[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        check("R1 no request after reset", txn_req, 0);
        for (int a = 0; a < 8; a++) rd(6'(a), "R1 reset value");
        rd(6'h01, "R2 unmapped 0x01");
        rd(6'h3f, "R2 unmapped 0x3f");

        // R7: every unsupported code
        wr(6'h02, 8'h40 | (3'd4 << 2));
        @(negedge clk) check("R7 no request code 4", txn_req, 0);
        rd(6'h00, "R7 error bit");
        wr(6'h02, 8'h40 | (3'd6 << 2));
        wr(6'h02, 8'hff);
        @(negedge clk) check("R7 no request code 7", txn_req, 0);
        rd(6'h02, "R3 control masked");
        wr(6'h00, 8'ha5);
        rd(6'h00, "R5 status cleared");

        // R4 wrap with 33 writes, R3/R5 rewinds
        for (int i = 0; i < 33; i++) wr(6'h07, 8'(8'h10 + i));
        rd(6'h07, "R4 index after wrap");
        rd(6'h02, "R3 control read rewinds");
        rd(6'h07, "R4 entry 0 overwritten by wrap");
        for (int i = 0; i < 31; i++) rd(6'h07, "R4 sequential read");
        rd(6'h07, "R4 read wraps to 0");
        wr(6'h00, 8'h00);
        rd(6'h07, "R5 status write rewinds");

        // transactions
        run_txn(3'd0, 1'b1, 7'h2a, 8'h11, 8'h22, 8'h33, 16'hbeef, 0);
        run_txn(3'd1, 1'b1, 7'h51, 8'h44, 8'h55, 8'h66, 16'h12c3, 0);
        run_txn(3'd1, 1'b0, 7'h05, 8'h77, 8'h88, 8'h99, 16'hffff, 0);
        run_txn(3'd2, 1'b1, 7'h7f, 8'h01, 8'h02, 8'h03, 16'h9a4b, 0);
        run_txn(3'd3, 1'b1, 7'h00, 8'hc0, 8'hc1, 8'hc2, 16'hd00d, 0);
        run_txn(3'd3, 1'b0, 7'h3c, 8'hab, 8'hcd, 8'hef, 16'h5555, 0);
        wr(6'h00, 8'h00);
        for (int i = 0; i < 6; i++) wr(6'h07, 8'($urandom));
        run_txn(3'd5, 1'b0, 7'h19, 8'h20, 8'h06, 8'h00, 16'h0000, 6);
        run_txn(3'd5, 1'b1, 7'h19, 8'h21, 8'h00, 8'h00, 16'h0005, 5);
        for (int i = 0; i < 5; i++) rd(6'h07, "R11 streamed byte in buffer");

        // random register traffic
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            logic [7:0] d = 8'($urandom);
            if (op < 4) begin
                wr(6'($urandom_range(3, 7)), d);
            end else if (op == 4) begin
                if (d[6] && proto_ok(d[4:2])) d[6] = 1'b0;
                wr(6'h02, d);
                @(negedge clk) check("R7 random control no request", txn_req, 0);
            end else if (op == 5) begin
                wr(6'h00, d);
            end else begin
                rd(6'($urandom_range(0, 15)), "R2 random read");
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule